// File: doc/BRIEF.md
# Error-Compensated Parallel Shift-Add Tree

This block sums Q signed P-bit words in one pass, with word j weighted by 2^-j. It is the final accumulation stage of a distributed-arithmetic inner product. All shifts are unrolled, so every word enters the same adder tree at the same time and no iteration takes place. The result keeps the resolution of word 0's LSB. The fractional columns below that point are not discarded. They are folded back into the result as a small rounded correction.

The integer-weight part of each shifted word is its arithmetic right shift. Sign extension keeps this part exact for negative inputs. The fractional bits of word j are its j lowest bits, and these are always non-negative. Each fractional bit falls into a column c, of weight 2^-c. The two heaviest columns (c = 1 and c = 2) are counted exactly. Every set bit in a lighter column (c >= 3) is credited a fixed weight of 1/16, an expected-value estimate. The resulting correction is rounded to the nearest integer and added to the integer sum. One output register carries the result, and a valid flag is aligned with it.

Top module: `ecat_sum`

## Requirements
- R1: While reset is held, out_valid is 0 and out_sum is 0.
- R2: out_valid equals in_valid of the previous clock cycle.
- R3: In a cycle where in_valid is low, out_sum keeps its value at the next clock edge.
- R4: Word j sits at bits [j*P +: P] of in_words as a two's complement value. The integer part of the result is the exact sum over j of floor(w_j / 2^j). All-zero inputs give 0.
- R5: A set fractional bit in column 1 adds 8 sixteenths to the correction accumulator. A set fractional bit in column 2 adds 4 sixteenths. Bit b of word j (b < j) lies in column j-b.
- R6: Each set fractional bit in a column c >= 3 adds 1 sixteenth, regardless of c.
- R7: The correction is floor((acc + 8) / 16), so an exact half rounds up. out_sum is the integer part plus the correction, and it appears one cycle after the inputs.
- R8: For any input, |out_sum - exact weighted sum| <= 2, in units of word 0's LSB.
- R9: Extreme inputs (all words at the most negative or most positive value) give the exact expected result without wrap-around. out_sum is OW = P + clog2(Q) + 1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input words are valid this cycle |
| in_words | input | Q*P | Q signed words, word j at [j*P +: P] |
| out_valid | output | 1 | out_sum holds a new result |
| out_sum | output | P+clog2(Q)+1 | Compensated, rounded weighted sum (signed) |

## Verification
The assertions check four things on every cycle: the valid alignment, holding of the result on idle cycles, a zero result for zero inputs, and the reset state. The exact bias arithmetic needs directed scenarios. These cover the column-1 half that rounds up, the column-2 quarter that rounds down, the flat 1/16 credit of the light columns, and all-minimum and all-maximum inputs. A bench model built bit by bit from the column rules checks each result exactly. The same model checks the 2-LSB error bound against the full-precision sum over random traffic.

// File: rtl/ecat_sum.sv
module ecat_sum #(
  parameter int P = 12,
  parameter int Q = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [Q*P-1:0]                  in_words,
  output logic                            out_valid,
  output logic signed [P+$clog2(Q):0]     out_sum
);
  localparam int OW = P + $clog2(Q) + 1;
  localparam int CW = $clog2(Q*Q) + 1;
  localparam int SW = CW + 4;

  logic signed [OW-1:0] main_sum, sum_d, wext;
  logic [CW-1:0]        c1, c2, cl;
  logic [SW-1:0]        acc;
  logic [OW-1:0]        bias;

  always_comb begin
    main_sum = '0;
    c1 = '0;
    c2 = '0;
    cl = '0;
    wext = '0;
    for (int j = 0; j < Q; j++) begin
      wext = OW'($signed(in_words[j*P +: P]));
      main_sum = main_sum + (wext >>> j);
      for (int b = 0; b < j; b++) begin
        if (in_words[j*P + b]) begin
          if (j - b == 1)      c1 = c1 + 1'b1;
          else if (j - b == 2) c2 = c2 + 1'b1;
          else                 cl = cl + 1'b1;
        end
      end
    end
  end

  assign acc   = (SW'(c1) << 3) + (SW'(c2) << 2) + SW'(cl) + SW'(8);
  assign bias  = OW'(acc >> 4);
  assign sum_d = main_sum + $signed(bias);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sum <= sum_d;
    end
  end
endmodule

// File: rtl/ecat_sum_chk.sv
module ecat_sum_chk #(
  parameter int P  = 12,
  parameter int Q  = 6,
  parameter int OW = P + $clog2(Q) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [Q*P-1:0]       in_words,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_sum
);
  logic prev_rst_low = 1'b0;

  always @(posedge clk) begin
    if (!rst_n && prev_rst_low)
      assert_reset_state_R1: assert (!out_valid && out_sum == '0);
    prev_rst_low <= !rst_n;
  end

  assert_valid_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(out_sum));

  assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_words) == '0) |-> out_sum == '0);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sum <= $signed(OW'(1 << P)) && out_sum >= -$signed(OW'(1 << P))));
endmodule

bind ecat_sum ecat_sum_chk #(.P(P), .Q(Q), .OW(OW)) u_chk (.*);

// File: tb/sim_ecat_sum.sv
`timescale 1ns/1ps
module sim_ecat_sum;
  localparam int P  = 12;
  localparam int Q  = 6;
  localparam int OW = P + $clog2(Q) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [Q*P-1:0] in_words = '0;
  logic out_valid;
  logic signed [OW-1:0] out_sum;

  int checks = 0, fails = 0;
  longint last_y = 0;
  bit done = 0;

  ecat_sum #(.P(P), .Q(Q)) u0 (.*);

  always #2.5 clk = ~clk;

  function automatic longint model(input logic [Q*P-1:0] v, output longint exact);
    longint main_s = 0, acc = 0;
    exact = 0;
    for (int j = 0; j < Q; j++) begin
      logic signed [P-1:0] ws;
      longint w;
      ws = v[j*P +: P];
      w = ws;
      main_s += w >>> j;
      exact  += w <<< (Q-1-j);
      for (int b = 0; b < j; b++)
        if (ws[b]) acc += (j-b == 1) ? 8 : (j-b == 2) ? 4 : 1;
    end
    return main_s + (acc + 8) / 16;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [Q*P-1:0] v, input bit vld);
    longint exp, exact, err;
    @(negedge clk);
    in_words = v;
    in_valid = vld;
    @(posedge clk);
    #1;
    check("R2", out_valid, vld);
    if (vld) begin
      exp = model(v, exact);
      check(req, out_sum, exp);
      err = longint'(out_sum) * (64'sd1 <<< (Q-1)) - exact;
      if (err < 0) err = -err;
      check("R8", (err <= (64'sd2 <<< (Q-1))) ? 1 : 0, 1);
      last_y = exp;
    end else begin
      check("R3", out_sum, last_y);
    end
  endtask

  function automatic logic [Q*P-1:0] one_word(input int j, input logic [P-1:0] w);
    logic [Q*P-1:0] v = '0;
    v[j*P +: P] = w;
    return v;
  endfunction

  initial begin
    logic [Q*P-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    check("R1", out_valid, 0);
    check("R1", out_sum, 0);
    @(negedge clk) rst_n = 1'b1;

    apply("R4", '0, 1);
    apply("R4", one_word(0, 12'd100), 1);
    apply("R4", one_word(3, 12'hF38), 1);
    apply("R7", one_word(1, 12'd1), 1);
    check("R7", out_sum, 1);
    apply("R5", one_word(2, 12'd1), 1);
    check("R5", out_sum, 0);
    apply("R5", one_word(3, 12'd7), 1);
    check("R5", out_sum, 1);
    v = one_word(2, 12'd1) | one_word(3, 12'd1) | one_word(4, 12'd3) | one_word(5, 12'd1);
    apply("R6", v, 1);
    check("R6", out_sum, 1);
    for (int j = 0; j < Q; j++) v[j*P +: P] = 12'h800;
    apply("R9", v, 1);
    check("R9", out_sum, -4032);
    for (int j = 0; j < Q; j++) v[j*P +: P] = 12'h7FF;
    apply("R9", v, 1);
    check("R9", out_sum, 4030);
    apply("R3", one_word(0, 12'd55), 0);
    apply("R3", one_word(1, 12'd77), 0);

    for (int n = 0; n < 400; n++) begin
      for (int j = 0; j < Q; j++) v[j*P +: P] = P'($urandom);
      apply("R8", v, ($urandom % 4) != 0);
    end

    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1", out_valid, 0);
    check("R1", out_sum, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule